// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits between an SDRAM command sequencer and the memory pins. The sequencer presents one candidate command each cycle: bank activate, column read, column write, bank precharge or auto refresh, together with a bank number. The guard answers in the same cycle. For the addressed bank it shows which of the five command kinds could be issued now without breaking a minimum delay. It also gives a single pass/hold answer for the command actually requested. The sequencer raises `issue` when it really drives a command onto the pins. The guard then updates its timing state from that command.

Minimum delays are set as parameters in picoseconds. They are turned into clock counts against a clock-period parameter, rounding up. Each bank keeps its own countdowns for the following windows:
- activate-to-activate
- precharge-to-activate
- activate-to-column
- activate-to-precharge
- write-to-precharge and write-to-column

One shared countdown spaces activates across banks, and another blocks everything after a refresh. Each bank also counts how long its row has been open and raises a flag once the open-row limit is passed.

A command issued while its ready answer is low is still applied to the timing state, because it reached the pins. It also sets a sticky violation flag that records the code of the first offending command. Reset is the only way to clear that flag.

Top module: `sdram_cmd_guard`

## Requirements
- R1: Each minimum delay in cycles is the smallest whole number of clock periods that is not shorter than the picosecond minimum, and is never less than 1. A command issued in cycle n starts a window of N cycles, so the dependent command is first ready in cycle n+N.
- R2: Bank activate (code 1) is ready for bank b only under all of these conditions:
  - bank b is closed.
  - at least the row-cycle count has passed since the last activate of b.
  - at least the precharge count has passed since the last precharge that closed b.
  - the conditions of R3 and R6 also hold.
- R3: A bank activate on any bank needs at least the activate-spacing count since the last activate on any bank.
- R4: Column read (code 2) and column write (code 3) are ready for bank b only when all of these hold:
  - bank b is open.
  - at least the activate-to-column count has passed since its activate.
  - the write-to-column count (1) has passed since its last write.
  - no refresh window is running.
  Back-to-back column commands are otherwise allowed every cycle.
- R5: Bank precharge (code 4) on an open bank needs both of these:
  - the minimum row-active count since its activate.
  - 2 cycles since its last write.
  On a closed bank, precharge is ready whenever no refresh window runs, and issuing it leaves that bank's state unchanged.
- R6: Auto refresh (code 5) is ready only when every bank is closed and every bank's activate window (R2) has expired. For the row-cycle count after a refresh, no command other than NOP (code 0) is ready.
- R7: `bank_overdue[b]` is high while bank b is open and more than the open-row limit (in cycles) has passed since its activate. It is low once the bank is precharged.
- R8: Issuing any command while its ready answer is low sets `viol_flag`. `viol_cmd` captures the code of the first such command, and both hold until reset. Codes 6 and 7 are never ready.
- R9: After reset all banks are closed, no row is overdue, and the violation flag and code are zero. Activate, precharge and refresh are ready, and read and write are not.
- R10: `cmd_ready` bit positions are bit 0 activate, bit 1 read, bit 2 write, bit 3 precharge and bit 4 refresh, all for `req_bank`. `req_ok` equals the bit for `req_cmd`, is 1 for NOP and is 0 for codes 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_cmd | input | 3 | Requested command code (0 NOP, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh) |
| req_bank | input | BANK_W | Bank addressed by the request |
| issue | input | 1 | The request is driven to the memory this cycle |
| cmd_ready | output | 5 | Per-command ready bits for `req_bank` |
| req_ok | output | 1 | Ready answer for `req_cmd` itself |
| bank_open | output | NUM_BANKS | Row-open state of each bank |
| bank_overdue | output | NUM_BANKS | Row open longer than the open-row limit |
| viol_flag | output | 1 | Sticky timing-violation flag |
| viol_cmd | output | 3 | Code of the first violating command |

## Verification
The bench builds the guard with a 4000 ps clock period and a 160 ns open-row limit. With these values the windows come out as follows:
- activate-to-column, precharge and activate-spacing round up from fractional values.
- the row-active minimum divides exactly.
- the open-row limit becomes 40 cycles, so overdue rows appear within a short run.

Small counts keep every window length reachable many times in a few thousand cycles. A stimulus sequence alternates between free mixes of all eight codes and precharge-and-refresh drains. The bench compares every ready bit, open bit and overdue bit each cycle against arithmetic on the cycle stamps of past commands, and directed steps cover rounding and forced violations.

// File: rtl/sdram_guard_pkg.sv
`timescale 1ns/1ps
package sdram_guard_pkg;

  typedef logic [2:0] cmd_t;

  localparam cmd_t CMD_NOP = 3'd0;
  localparam cmd_t CMD_ACT = 3'd1;
  localparam cmd_t CMD_RD  = 3'd2;
  localparam cmd_t CMD_WR  = 3'd3;
  localparam cmd_t CMD_PRE = 3'd4;
  localparam cmd_t CMD_REF = 3'd5;

  // Ready-vector bit positions.
  localparam int RB_ACT = 0;
  localparam int RB_RD  = 1;
  localparam int RB_WR  = 2;
  localparam int RB_PRE = 3;
  localparam int RB_REF = 4;
  localparam int RB_NUM = 5;

  // Picoseconds to clock cycles, rounded up, at least one cycle.
  function automatic int ps_to_cycles(input int ps, input int period_ps);
    int c;
    c = (ps + period_ps - 1) / period_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold values 0..v.
  function automatic int width_for(input int v);
    int w;
    w = $clog2(v + 1);
    if (w < 1) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/sdram_bank_timer.sv
`timescale 1ns/1ps
module sdram_bank_timer #(
  parameter int RC_CYC      = 11,
  parameter int RP_CYC      = 3,
  parameter int RCD_CYC     = 3,
  parameter int RAS_CYC     = 8,
  parameter int WR_PRE_CYC  = 2,
  parameter int WR_COL_CYC  = 1,
  parameter int RAS_MAX_CYC = 100,
  parameter int CNT_W       = 4,
  parameter int AGE_W       = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_fire,
  input  logic pre_fire,
  input  logic wr_fire,
  output logic open_o,
  output logic act_rdy_o,
  output logic col_rdy_o,
  output logic pre_rdy_o,
  output logic overdue_o
);

  localparam logic [CNT_W-1:0] LD_RC    = CNT_W'(RC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RP    = CNT_W'(RP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RCD   = CNT_W'(RCD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RAS   = CNT_W'(RAS_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WRPRE = CNT_W'(WR_PRE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WRCOL = CNT_W'(WR_COL_CYC - 1);
  localparam logic [AGE_W-1:0] AGE_SAT  = AGE_W'(RAS_MAX_CYC + 1);
  localparam logic [AGE_W-1:0] AGE_LIM  = AGE_W'(RAS_MAX_CYC);

  logic             open_q;
  logic [CNT_W-1:0] act_w_q, col_w_q, pre_w_q;
  logic [AGE_W-1:0] age_q;
  logic             pre_close;

  // Countdown step: decrement to zero, or reload if the new window is longer.
  function automatic logic [CNT_W-1:0] step_wait(input logic [CNT_W-1:0] cur,
                                                  input logic fire,
                                                  input logic [CNT_W-1:0] load);
    logic [CNT_W-1:0] dec;
    dec = (cur == '0) ? '0 : cur - 1'b1;
    if (fire && (load > dec)) return load;
    return dec;
  endfunction

  // Precharge only acts on an open row.
  assign pre_close = pre_fire && open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      act_w_q <= '0;
      col_w_q <= '0;
      pre_w_q <= '0;
      age_q   <= '0;
    end else begin
      if (act_fire)       open_q <= 1'b1;
      else if (pre_close) open_q <= 1'b0;

      if (act_fire)
        act_w_q <= step_wait(act_w_q, 1'b1, LD_RC);
      else
        act_w_q <= step_wait(act_w_q, pre_close, LD_RP);

      if (act_fire)
        col_w_q <= step_wait(col_w_q, 1'b1, LD_RCD);
      else
        col_w_q <= step_wait(col_w_q, wr_fire, LD_WRCOL);

      if (act_fire)
        pre_w_q <= step_wait(pre_w_q, 1'b1, LD_RAS);
      else
        pre_w_q <= step_wait(pre_w_q, wr_fire, LD_WRPRE);

      if (act_fire)                       age_q <= AGE_W'(1);
      else if (pre_close)                 age_q <= '0;
      else if (open_q && age_q != AGE_SAT) age_q <= age_q + 1'b1;
    end
  end

  assign open_o    = open_q;
  assign act_rdy_o = !open_q && (act_w_q == '0);
  assign col_rdy_o = open_q && (col_w_q == '0);
  assign pre_rdy_o = !open_q || (pre_w_q == '0);
  assign overdue_o = open_q && (age_q > AGE_LIM);

  // Assertions
  generate
    if (RCD_CYC > 1) begin : g_a_rcd
      assert_rcd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |=> !col_rdy_o);
    end
    if (RAS_CYC > 1) begin : g_a_ras
      assert_ras_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |=> !pre_rdy_o);
    end
    if (WR_PRE_CYC > 1) begin : g_a_wr
      assert_wr_recover_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && open_q && !act_fire && !pre_fire) |=> !pre_rdy_o);
    end
    if (RP_CYC > 1) begin : g_a_rp
      assert_rp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_fire && open_q) |=> !act_rdy_o);
    end
  endgenerate

  assert_overdue_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overdue_o && !act_fire && !pre_fire) |=> overdue_o);
  assert_overdue_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_fire && open_q && !act_fire) |=> !overdue_o);

endmodule

// File: rtl/sdram_global_timer.sv
`timescale 1ns/1ps
module sdram_global_timer #(
  parameter int RRD_CYC = 2,
  parameter int RFC_CYC = 11,
  parameter int CNT_W   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_act_fire,
  input  logic ref_fire,
  output logic rrd_clear_o,
  output logic ref_clear_o
);

  localparam logic [CNT_W-1:0] LD_RRD = CNT_W'(RRD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(RFC_CYC - 1);

  logic [CNT_W-1:0] rrd_q, rfc_q;

  function automatic logic [CNT_W-1:0] count_down(input logic [CNT_W-1:0] cur,
                                                   input logic fire,
                                                   input logic [CNT_W-1:0] load);
    if (fire) return load;
    return (cur == '0) ? '0 : cur - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_q <= '0;
      rfc_q <= '0;
    end else begin
      rrd_q <= count_down(rrd_q, any_act_fire, LD_RRD);
      rfc_q <= count_down(rfc_q, ref_fire, LD_RFC);
    end
  end

  assign rrd_clear_o = (rrd_q == '0);
  assign ref_clear_o = (rfc_q == '0);

  generate
    if (RRD_CYC > 1) begin : g_a_rrd
      assert_act_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        any_act_fire |=> !rrd_clear_o);
    end
    if (RFC_CYC > 1) begin : g_a_rfc
      assert_refresh_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_fire |=> !ref_clear_o);
    end
  endgenerate

endmodule

// File: rtl/sdram_viol_log.sv
`timescale 1ns/1ps
module sdram_viol_log
  import sdram_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic cmd_ok,
  input  cmd_t cmd,
  output logic flag_o,
  output cmd_t code_o
);

  logic bad_issue;
  logic flag_q;
  cmd_t code_q;

  assign bad_issue = issue && !cmd_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      code_q <= CMD_NOP;
    end else if (bad_issue && !flag_q) begin
      flag_q <= 1'b1;
      code_q <= cmd;
    end
  end

  assign flag_o = flag_q;
  assign code_o = code_q;

  assert_viol_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> (flag_q && $stable(code_q)));
  assert_viol_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_issue |=> flag_q);

endmodule

// File: rtl/sdram_cmd_guard.sv
`timescale 1ns/1ps
module sdram_cmd_guard
  import sdram_guard_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int CLK_PERIOD_PS = 6000,
  parameter int T_RRD_PS      = 12000,
  parameter int T_RCD_PS      = 18000,
  parameter int T_RP_PS       = 18000,
  parameter int T_RAS_PS      = 42000,
  parameter int T_RC_PS       = 60000,
  parameter int T_RFC_PS      = 60000,
  parameter int T_RAS_MAX_PS  = 100000000,
  parameter int WR_COL_CYC    = 1,
  parameter int WR_PRE_CYC    = 2,
  localparam int BANK_W       = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              issue,
  output logic [4:0]        cmd_ready,
  output logic              req_ok,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [NUM_BANKS-1:0] bank_overdue,
  output logic              viol_flag,
  output logic [2:0]        viol_cmd
);

  localparam int RRD_CYC = ps_to_cycles(T_RRD_PS, CLK_PERIOD_PS);
  localparam int RCD_CYC = ps_to_cycles(T_RCD_PS, CLK_PERIOD_PS);
  localparam int RP_CYC  = ps_to_cycles(T_RP_PS, CLK_PERIOD_PS);
  localparam int RAS_CYC = ps_to_cycles(T_RAS_PS, CLK_PERIOD_PS);
  localparam int RC_CYC  = ps_to_cycles(T_RC_PS, CLK_PERIOD_PS);
  localparam int RFC_CYC = ps_to_cycles(T_RFC_PS, CLK_PERIOD_PS);
  localparam int RAS_MAX_CYC = ps_to_cycles(T_RAS_MAX_PS, CLK_PERIOD_PS);
  localparam int MAX_WIN = imax(imax(imax(RRD_CYC, RCD_CYC), imax(RP_CYC, RAS_CYC)),
                                imax(imax(RC_CYC, RFC_CYC), imax(WR_COL_CYC, WR_PRE_CYC)));
  localparam int CNT_W = width_for(MAX_WIN);
  localparam int AGE_W = width_for(RAS_MAX_CYC + 1);

  // Named internal events
  logic [NUM_BANKS-1:0] bank_hit;
  logic [NUM_BANKS-1:0] act_fire, pre_fire, wr_fire;
  logic [NUM_BANKS-1:0] b_act_rdy, b_col_rdy, b_pre_rdy;
  logic                 any_act_fire, ref_fire;
  logic                 rrd_clear, ref_clear;
  logic                 all_banks_idle;
  logic                 sel_act, sel_col, sel_pre;

  assign any_act_fire = issue && (req_cmd == CMD_ACT);
  assign ref_fire     = issue && (req_cmd == CMD_REF);

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign bank_hit[b] = (req_bank == BANK_W'(b));
      assign act_fire[b] = any_act_fire && bank_hit[b];
      assign pre_fire[b] = issue && (req_cmd == CMD_PRE) && bank_hit[b];
      assign wr_fire[b]  = issue && (req_cmd == CMD_WR)  && bank_hit[b];

      sdram_bank_timer #(
        .RC_CYC      (RC_CYC),
        .RP_CYC      (RP_CYC),
        .RCD_CYC     (RCD_CYC),
        .RAS_CYC     (RAS_CYC),
        .WR_PRE_CYC  (WR_PRE_CYC),
        .WR_COL_CYC  (WR_COL_CYC),
        .RAS_MAX_CYC (RAS_MAX_CYC),
        .CNT_W       (CNT_W),
        .AGE_W       (AGE_W)
      ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_fire  (act_fire[b]),
        .pre_fire  (pre_fire[b]),
        .wr_fire   (wr_fire[b]),
        .open_o    (bank_open[b]),
        .act_rdy_o (b_act_rdy[b]),
        .col_rdy_o (b_col_rdy[b]),
        .pre_rdy_o (b_pre_rdy[b]),
        .overdue_o (bank_overdue[b])
      );
    end
  endgenerate

  sdram_global_timer #(
    .RRD_CYC (RRD_CYC),
    .RFC_CYC (RFC_CYC),
    .CNT_W   (CNT_W)
  ) u_global (
    .clk          (clk),
    .rst_n        (rst_n),
    .any_act_fire (any_act_fire),
    .ref_fire     (ref_fire),
    .rrd_clear_o  (rrd_clear),
    .ref_clear_o  (ref_clear)
  );

  assign all_banks_idle = &b_act_rdy;
  assign sel_act = b_act_rdy[req_bank];
  assign sel_col = b_col_rdy[req_bank];
  assign sel_pre = b_pre_rdy[req_bank];

  always_comb begin
    cmd_ready         = '0;
    cmd_ready[RB_ACT] = sel_act && rrd_clear && ref_clear;
    cmd_ready[RB_RD]  = sel_col && ref_clear;
    cmd_ready[RB_WR]  = sel_col && ref_clear;
    cmd_ready[RB_PRE] = sel_pre && ref_clear;
    cmd_ready[RB_REF] = all_banks_idle && ref_clear;
  end

  always_comb begin
    case (req_cmd)
      CMD_NOP: req_ok = 1'b1;
      CMD_ACT: req_ok = cmd_ready[RB_ACT];
      CMD_RD:  req_ok = cmd_ready[RB_RD];
      CMD_WR:  req_ok = cmd_ready[RB_WR];
      CMD_PRE: req_ok = cmd_ready[RB_PRE];
      CMD_REF: req_ok = cmd_ready[RB_REF];
      default: req_ok = 1'b0;
    endcase
  end

  sdram_viol_log u_viol (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue  (issue),
    .cmd_ok (req_ok),
    .cmd    (req_cmd),
    .flag_o (viol_flag),
    .code_o (viol_cmd)
  );

  generate
    if (RFC_CYC > 1) begin : g_a_ref
      assert_refresh_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_fire |=> (cmd_ready == '0));
    end
  endgenerate

  assert_one_bank_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_fire));

endmodule

// File: tb/sdram_cmd_guard_tb.sv
`timescale 1ns/1ps
module sdram_cmd_guard_tb_top;

  localparam int PER     = 4000;
  localparam int P_RRD   = 10000;
  localparam int P_RCD   = 15000;
  localparam int P_RP    = 15000;
  localparam int P_RAS   = 40000;
  localparam int P_RC    = 55000;
  localparam int P_RFC   = 55000;
  localparam int P_RMAX  = 160000;
  localparam int NB      = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req_cmd = 3'd0;
  logic [1:0] req_bank = 2'd0;
  logic       issue = 1'b0;
  logic [4:0] cmd_ready;
  logic       req_ok;
  logic [NB-1:0] bank_open, bank_overdue;
  logic       viol_flag;
  logic [2:0] viol_cmd;

  always #10 clk = ~clk;

  sdram_cmd_guard #(
    .NUM_BANKS(NB), .CLK_PERIOD_PS(PER), .T_RRD_PS(P_RRD), .T_RCD_PS(P_RCD),
    .T_RP_PS(P_RP), .T_RAS_PS(P_RAS), .T_RC_PS(P_RC), .T_RFC_PS(P_RFC),
    .T_RAS_MAX_PS(P_RMAX), .WR_COL_CYC(1), .WR_PRE_CYC(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_bank(req_bank), .issue(issue),
    .cmd_ready(cmd_ready), .req_ok(req_ok), .bank_open(bank_open),
    .bank_overdue(bank_overdue), .viol_flag(viol_flag), .viol_cmd(viol_cmd)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // Smallest k with k periods covering the minimum.
  function automatic int cycles_for(input int ps);
    int k = 1;
    while (k * PER < ps) k++;
    return k;
  endfunction

  int c_rrd, c_rcd, c_rp, c_ras, c_rc, c_rfc, c_rmax;

  // Bench model: cycle stamps
  int now;
  int t_act[NB], t_pre[NB], t_wr[NB];
  int t_any_act, t_ref;
  bit m_open[NB];

  task automatic model_reset();
    now = 0;
    for (int b = 0; b < NB; b++) begin
      t_act[b] = -1000; t_pre[b] = -1000; t_wr[b] = -1000; m_open[b] = 0;
    end
    t_any_act = -1000; t_ref = -1000;
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: got %0d expected %0d", tag, now, got, exp);
    end
  endtask

  function automatic bit exp_noref();
    return (now - t_ref) >= c_rfc;
  endfunction

  function automatic bit exp_act(input int b);
    return exp_noref() && !m_open[b] && (now - t_act[b] >= c_rc) &&
           (now - t_pre[b] >= c_rp) && (now - t_any_act >= c_rrd);
  endfunction

  function automatic bit exp_col(input int b);
    return exp_noref() && m_open[b] && (now - t_act[b] >= c_rcd) && (now - t_wr[b] >= 1);
  endfunction

  function automatic bit exp_pre(input int b);
    return exp_noref() && (!m_open[b] || ((now - t_act[b] >= c_ras) && (now - t_wr[b] >= 2)));
  endfunction

  function automatic bit exp_ref();
    bit ok = exp_noref();
    for (int b = 0; b < NB; b++)
      if (m_open[b] || (now - t_act[b] < c_rc) || (now - t_pre[b] < c_rp)) ok = 0;
    return ok;
  endfunction

  function automatic bit exp_ok(input int cmd, input int b);
    case (cmd)
      0: return 1;
      1: return exp_act(b);
      2: return exp_col(b);
      3: return exp_col(b);
      4: return exp_pre(b);
      5: return exp_ref();
      default: return 0;
    endcase
  endfunction

  task automatic model_issue(input int cmd, input int b);
    case (cmd)
      1: begin m_open[b] = 1; t_act[b] = now; t_any_act = now; end
      3: t_wr[b] = now;
      4: if (m_open[b]) begin m_open[b] = 0; t_pre[b] = now; end
      5: t_ref = now;
      default: ;
    endcase
  endtask

  // Compare all outputs against the model for the current request.
  task automatic compare_all(input int cmd, input int b);
    int ov;
    chk("R2 act bit0", cmd_ready[0], exp_act(b));
    chk("R4 rd bit1", cmd_ready[1], exp_col(b));
    chk("R4 wr bit2", cmd_ready[2], exp_col(b));
    chk("R5 pre bit3", cmd_ready[3], exp_pre(b));
    chk("R6 ref bit4", cmd_ready[4], exp_ref());
    chk("R10 req_ok", req_ok, exp_ok(cmd, b));
    for (int k = 0; k < NB; k++) begin
      ov = (m_open[k] && (now - t_act[k] > c_rmax)) ? 1 : 0;
      chk("R7 overdue", bank_overdue[k], ov);
      chk("R2 open", bank_open[k], m_open[k]);
    end
  endtask

  // One cycle: present request, compare, optionally issue.
  task automatic cycle(input int cmd, input int b, input bit force_iss, input bit want);
    bit iss;
    @(negedge clk);
    req_cmd = 3'(cmd); req_bank = 2'(b); issue = 1'b0;
    #1;
    compare_all(cmd, b);
    iss = force_iss || (want && exp_ok(cmd, b) && cmd != 0);
    issue = iss;
    @(posedge clk);
    if (iss) model_issue(cmd, b);
    now++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; issue = 1'b0; req_cmd = 3'd0; req_bank = 2'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    int cmd, bnk, meas;
    c_rrd = cycles_for(P_RRD); c_rcd = cycles_for(P_RCD); c_rp = cycles_for(P_RP);
    c_ras = cycles_for(P_RAS); c_rc = cycles_for(P_RC); c_rfc = cycles_for(P_RFC);
    c_rmax = cycles_for(P_RMAX);

    do_reset();
    // R9: reset state
    #1;
    req_cmd = 3'd0; req_bank = 2'd0; #1;
    chk("R9 ready after reset", cmd_ready, 5'b11001);
    chk("R9 open after reset", bank_open, 0);
    chk("R9 overdue after reset", bank_overdue, 0);
    chk("R9 viol flag after reset", viol_flag, 0);
    chk("R9 viol code after reset", viol_cmd, 0);

    // R1: rounding of activate-to-column (15000/4000 -> 4 cycles)
    cycle(1, 1, 1'b0, 1'b1);
    meas = 1;
    while (meas < 50) begin
      @(negedge clk); req_cmd = 3'd2; req_bank = 2'd1; issue = 1'b0; #1;
      if (cmd_ready[1]) break;
      @(posedge clk); now++; meas++;
    end
    chk("R1 act-to-read cycles", meas, 4);
    chk("R1 rounded count", c_rcd, 4);
    chk("R1 exact count", c_ras, 10);
    chk("R1 spacing count", c_rrd, 3);

    // Main sweep
    do_reset();
    lf = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      bnk = int'(lf[7:6]);
      if ((i / 150) % 3 == 2)
        cmd = lf[0] ? 4 : (lf[1] ? 5 : 0);
      else
        cmd = int'(lf[2:0]);
      cycle(cmd, bnk, 1'b0, lf[5:4] != 2'b00);
    end
    chk("R8 no violation after legal traffic", viol_flag, 0);

    // R8: forced violations
    do_reset();
    cycle(1, 0, 1'b0, 1'b1);
    @(negedge clk); req_cmd = 3'd2; req_bank = 2'd0; #1;
    chk("R8 read not ready", req_ok, 0);
    issue = 1'b1; @(posedge clk); now++;
    @(negedge clk); issue = 1'b0; req_cmd = 3'd7; req_bank = 2'd1; #1;
    chk("R8 flag set", viol_flag, 1);
    chk("R8 code captured", viol_cmd, 2);
    chk("R8 code 7 never ready", req_ok, 0);
    issue = 1'b1; @(posedge clk);
    @(negedge clk); issue = 1'b0; #1;
    chk("R8 flag held", viol_flag, 1);
    chk("R8 first code kept", viol_cmd, 2);

    // R5: precharge on a closed bank leaves it untouched
    do_reset();
    cycle(4, 2, 1'b0, 1'b1);
    @(negedge clk); req_cmd = 3'd1; req_bank = 2'd2; #1;
    chk("R5 idle precharge leaves bank closed", bank_open[2], 0);
    chk("R5 idle precharge keeps act ready", cmd_ready[0], 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule